// File: doc/BRIEF.md
# Expansion ROM select logic

This block steers reads in the peripheral firmware window, pages 0xC1 through 0xCF, to one of two sources: the ROM on the peripheral card in that slot, or the internal firmware ROM. For each access it raises one of two select outputs. The ROM data path sits outside the block and uses these selects to choose its source. Nothing in the window is writable, so a write never raises either select and is lost.

Three flags drive the choice. The first sends the whole window to internal ROM. The second lets the card in slot 3 answer page 0xC3. The third is a latch that hands the shared pages 0xC8 to 0xCF to internal ROM. Software sets and clears the first two by writing switch addresses in the I/O page 0xC0, and reads their state back through two status addresses.

The latch is a two-state machine, with no software write to set it. In `EXP_FREE` the shared pages belong to the slot cards. In `EXP_HELD` they belong to internal ROM. The machine has three transitions:
- CLAIM goes from `EXP_FREE` to `EXP_HELD` on a read of page 0xC3 that internal ROM serves.
- RELEASE goes from `EXP_HELD` to `EXP_FREE` on a read of 0xCFFF that internal ROM serves.
- FORCE goes from `EXP_HELD` to `EXP_FREE` on a write to switch 0xC006.

Every other cycle leaves the state where it is. The machine changes state at the clock edge that ends the access, so the access that triggers a transition is still decoded with the old state.

Top module: `exprom_select`

## Requirements
- R1: Reset clears all three flags. After reset, both status bits read 0 and `exp_active` is 0. A read of page 0xC3 is then served by internal ROM, and a read of page 0xC8 is served by the slot.
- R2: The four switch writes act as follows:
  - A write to 0xC007 sets the internal-for-all flag.
  - A write to 0xC006 clears the internal-for-all flag and also clears the latch (FORCE).
  - A write to 0xC00B enables slot-3 ROM.
  - A write to 0xC00A disables slot-3 ROM.
  - A read of any of these four addresses changes no flag.
- R3: While the internal-for-all flag is set, every read of 0xC100 to 0xCFFF gives `sel_int`=1 and `sel_slot`=0.
- R4: While the internal-for-all flag is clear, a read of 0xC100 to 0xCFFF gives `sel_slot`=1, with two exceptions that give `sel_int`=1 instead:
  - page 0xC3 when slot-3 ROM is disabled;
  - pages 0xC8 to 0xCF while `exp_active`=1.
- R5: A read of page 0xC3 that gives `sel_int`=1 sets `exp_active` from the next cycle on. The read itself is decoded with the value before the update.
- R6: A read of 0xCFFF that gives `sel_int`=1 clears `exp_active` from the next cycle on. The read itself is still served by internal ROM.
- R7: The latch keeps its value in these cases:
  - a read of page 0xC3 that gives `sel_slot`=1;
  - a read of 0xCFFF that gives `sel_slot`=1;
  - idle cycles, in which neither `cpu_rd` nor `cpu_wr` is high.
- R8: A read of 0xC015 or 0xC017 gives `stat_valid`=1. Bit 7 of `stat_data` then equals the internal-for-all flag or the slot-3 enable flag respectively, and bits 6..0 are 0. On every other cycle `stat_valid`=0 and `stat_data`=0.
- R9: Two kinds of cycle give `sel_int`=`sel_slot`=0:
  - any cycle with `cpu_wr` high, whether or not `cpu_rd` is also high; such a cycle counts as a write and never changes the latch;
  - a read outside 0xC100 to 0xCFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one CPU access per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_rd | input | 1 | Read strobe for the current cycle |
| cpu_wr | input | 1 | Write strobe for the current cycle; overrides `cpu_rd` |
| sel_int | output | 1 | Current read is served by internal ROM |
| sel_slot | output | 1 | Current read is served by peripheral slot ROM |
| stat_valid | output | 1 | Current read hits a status address |
| stat_data | output | 8 | Status byte, flag in bit 7 |
| exp_active | output | 1 | Latch state: 1 means the shared pages are claimed by internal ROM |

## Verification
The bench aims at the cycle in which the latch changes. A design that applied CLAIM to the triggering read itself would report page 0xC3 correctly but would serve the next 0xC8 read wrongly only when the timing slipped the other way. The bench therefore checks the read just after the trigger as well as the trigger read.

When slot-3 ROM is enabled, page 0xC3 reads and slot-served 0xCFFF reads must leave the latch alone. A design that claimed on every 0xC3 read would serve the following 0xC800 read from internal ROM, and the bench catches it there.

Writes, including a cycle with both strobes high, must raise no select and must not claim. The 0xC006 write must clear the latch as well as the flag, or the next 0xC800 read would still go internal. A reset taken with every flag set must bring back the power-up mapping.

// File: rtl/exprom_pkg.sv
package exprom_pkg;
    localparam int ADDR_W = 16;
    localparam int PAGE_W = 8;
    localparam int OFF_W  = ADDR_W - PAGE_W;

    localparam logic [PAGE_W-1:0] PG_IO        = 8'hC0;
    localparam logic [PAGE_W-1:0] PG_SLOT3     = 8'hC3;
    localparam logic [PAGE_W-1:0] PG_SHARED_LO = 8'hC8;
    localparam logic [PAGE_W-1:0] PG_LAST      = 8'hCF;

    localparam logic [OFF_W-1:0] SW_CX_CLR = 8'h06;
    localparam logic [OFF_W-1:0] SW_CX_SET = 8'h07;
    localparam logic [OFF_W-1:0] SW_S3_CLR = 8'h0A;
    localparam logic [OFF_W-1:0] SW_S3_SET = 8'h0B;
    localparam logic [OFF_W-1:0] ST_CX     = 8'h15;
    localparam logic [OFF_W-1:0] ST_S3     = 8'h17;

    localparam logic [ADDR_W-1:0] REL_ADDR = {PG_LAST, {OFF_W{1'b1}}};

    typedef enum logic {
        EXP_FREE = 1'b0,
        EXP_HELD = 1'b1
    } exp_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_CLAIM,
        EV_RELEASE,
        EV_FORCE
    } exp_event_t;

    typedef struct packed {
        logic int_all;
        logic slot3_en;
    } mode_flags_t;
endpackage

// File: rtl/exprom_mode_regs.sv
module exprom_mode_regs
    import exprom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_acc,
    input  logic              wr_acc,
    output mode_flags_t       flags,
    output logic              force_clr,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic              io_hit;

    assign page   = addr[ADDR_W-1:OFF_W];
    assign off    = addr[OFF_W-1:0];
    assign io_hit = (page == PG_IO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wr_acc && io_hit) begin
            case (off)
                SW_CX_SET: flags.int_all  <= 1'b1;
                SW_CX_CLR: flags.int_all  <= 1'b0;
                SW_S3_SET: flags.slot3_en <= 1'b1;
                SW_S3_CLR: flags.slot3_en <= 1'b0;
                default:   ;
            endcase
        end
    end

    assign force_clr = wr_acc && io_hit && (off == SW_CX_CLR);

    always_comb begin
        stat_valid = 1'b0;
        stat_data  = '0;
        if (rd_acc && io_hit) begin
            case (off)
                ST_CX: begin
                    stat_valid         = 1'b1;
                    stat_data[FLAG_BIT] = flags.int_all;
                end
                ST_S3: begin
                    stat_valid         = 1'b1;
                    stat_data[FLAG_BIT] = flags.slot3_en;
                end
                default: ;
            endcase
        end
    end

    AST_READ_LEAVES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> $stable(flags));  // R2

    AST_CX_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && io_hit && off == SW_CX_SET) |=> flags.int_all);  // R2
endmodule

// File: rtl/exprom_page_decode.sv
module exprom_page_decode
    import exprom_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_acc,
    input  mode_flags_t       flags,
    input  logic              exp_held,
    output logic              sel_int,
    output logic              sel_slot,
    output logic              claim_hit,
    output logic              release_hit
);
    logic [PAGE_W-1:0] page;
    logic              in_region;
    logic              int_page;

    assign page      = addr[ADDR_W-1:OFF_W];
    assign in_region = (page > PG_IO) && (page <= PG_LAST);

    always_comb begin
        if (flags.int_all) begin
            int_page = 1'b1;
        end else if (page == PG_SLOT3) begin
            int_page = !flags.slot3_en;
        end else if (page >= PG_SHARED_LO) begin
            int_page = exp_held;
        end else begin
            int_page = 1'b0;
        end
    end

    assign sel_int     = rd_acc && in_region && int_page;
    assign sel_slot    = rd_acc && in_region && !int_page;
    assign claim_hit   = sel_int && (page == PG_SLOT3);
    assign release_hit = sel_int && (addr == REL_ADDR);
endmodule

// File: rtl/exprom_exp_fsm.sv
module exprom_exp_fsm
    import exprom_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_hit,
    input  logic release_hit,
    input  logic force_clr,
    output logic exp_held
);
    exp_state_t state_q;
    exp_state_t state_d;
    exp_event_t ev;

    always_comb begin
        if (force_clr) begin
            ev = EV_FORCE;
        end else if (claim_hit) begin
            ev = EV_CLAIM;
        end else if (release_hit) begin
            ev = EV_RELEASE;
        end else begin
            ev = EV_NONE;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXP_FREE: begin
                if (ev == EV_CLAIM) begin
                    state_d = EXP_HELD;
                end
            end
            EXP_HELD: begin
                if (ev == EV_RELEASE || ev == EV_FORCE) begin
                    state_d = EXP_FREE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EXP_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    assign exp_held = (state_q == EXP_HELD);

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |=> exp_held);  // R5

    AST_RELEASE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (release_hit && !claim_hit) |=> !exp_held);  // R6

    AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> !exp_held);  // R2

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_hit && !release_hit && !force_clr) |=> $stable(exp_held));  // R7
endmodule

// File: rtl/exprom_select.sv
module exprom_select
    import exprom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic              sel_int,
    output logic              sel_slot,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data,
    output logic              exp_active
);
    logic        rd_acc;
    logic        wr_acc;
    mode_flags_t flags;
    logic        force_clr;
    logic        claim_hit;
    logic        release_hit;
    logic        exp_held;

    assign wr_acc = cpu_wr;
    assign rd_acc = cpu_rd && !cpu_wr;

    exprom_mode_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (cpu_addr),
        .rd_acc     (rd_acc),
        .wr_acc     (wr_acc),
        .flags      (flags),
        .force_clr  (force_clr),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    exprom_page_decode u_dec (
        .addr        (cpu_addr),
        .rd_acc      (rd_acc),
        .flags       (flags),
        .exp_held    (exp_held),
        .sel_int     (sel_int),
        .sel_slot    (sel_slot),
        .claim_hit   (claim_hit),
        .release_hit (release_hit)
    );

    exprom_exp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_hit   (claim_hit),
        .release_hit (release_hit),
        .force_clr   (force_clr),
        .exp_held    (exp_held)
    );

    assign exp_active = exp_held;

    AST_WRITE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (!sel_int && !sel_slot));  // R9

    AST_INT_ALL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        flags.int_all |-> !sel_slot);  // R3

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_int, sel_slot}));  // R4

    AST_STAT_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (!sel_int && !sel_slot));  // R8

    AST_WRITE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !exp_active) |=> !exp_active);  // R9
endmodule

// File: tb/sim_exprom_select.sv
`timescale 1ns/100ps
module sim_exprom_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        sel_int, sel_slot, stat_valid, exp_active;
    logic [7:0]  stat_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exprom_select u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .sel_int(sel_int), .sel_slot(sel_slot),
        .stat_valid(stat_valid), .stat_data(stat_data), .exp_active(exp_active)
    );

    // op: 0 idle, 1 read, 2 write, 3 both strobes
    // expect: {sel_int, sel_slot, stat_valid, stat_data[7], exp_active}
    localparam int NV = 37;
    localparam logic [26:0] VEC [NV] = '{
        {2'd1, 16'hC100, 5'b01000, 4'd4},  // R4 plain slot page
        {2'd1, 16'hC3A0, 5'b10000, 4'd5},  // R5 claim, old value used
        {2'd1, 16'hC800, 5'b10001, 4'd5},  // R5 shared page now internal
        {2'd1, 16'hC015, 5'b00101, 4'd8},  // R8 status int flag 0
        {2'd2, 16'hC00B, 5'b00001, 4'd2},  // R2 slot3 on
        {2'd1, 16'hC017, 5'b00111, 4'd8},  // R8 status slot3 1
        {2'd1, 16'hC300, 5'b01001, 4'd7},  // R7 slot-served C3, no change
        {2'd1, 16'hCFFF, 5'b10001, 4'd6},  // R6 release read still internal
        {2'd1, 16'hCFFF, 5'b01000, 4'd6},  // R6 released
        {2'd1, 16'hC3FF, 5'b01000, 4'd7},  // R7 no claim from slot
        {2'd1, 16'hC800, 5'b01000, 4'd7},  // R7 still free
        {2'd2, 16'hC300, 5'b00000, 4'd9},  // R9 write discarded
        {2'd3, 16'hC310, 5'b00000, 4'd9},  // R9 both strobes = write
        {2'd1, 16'hC800, 5'b01000, 4'd9},  // R9 writes did not claim
        {2'd1, 16'hC00A, 5'b00000, 4'd2},  // R2 switch read
        {2'd1, 16'hC006, 5'b00000, 4'd2},  // R2 switch read
        {2'd1, 16'hC017, 5'b00110, 4'd2},  // R2 slot3 still set
        {2'd2, 16'hC007, 5'b00000, 4'd2},  // R2 int all on
        {2'd1, 16'hC015, 5'b00110, 4'd8},  // R8 status int flag 1
        {2'd1, 16'hC100, 5'b10000, 4'd3},  // R3
        {2'd1, 16'hC3C0, 5'b10000, 4'd3},  // R3 claims too
        {2'd1, 16'hC9FF, 5'b10001, 4'd3},  // R3
        {2'd1, 16'hC007, 5'b00001, 4'd2},  // R2 switch read
        {2'd1, 16'hC015, 5'b00111, 4'd2},  // R2 int flag kept
        {2'd2, 16'hC006, 5'b00001, 4'd2},  // R2 clear int and latch
        {2'd1, 16'hC015, 5'b00100, 4'd2},  // R2 both cleared
        {2'd1, 16'hC800, 5'b01000, 4'd2},  // R2 shared back to slot
        {2'd2, 16'hC00A, 5'b00000, 4'd2},  // R2 slot3 off
        {2'd1, 16'hC017, 5'b00100, 4'd8},  // R8
        {2'd1, 16'hC3FF, 5'b10000, 4'd5},  // R5 claim
        {2'd1, 16'hCFFE, 5'b10001, 4'd5},  // R5
        {2'd0, 16'hCFFF, 5'b00001, 4'd7},  // R7 idle keeps latch
        {2'd1, 16'hD000, 5'b00001, 4'd9},  // R9 outside window
        {2'd1, 16'hC0FF, 5'b00001, 4'd9},  // R9 I/O page
        {2'd1, 16'hCFFF, 5'b10001, 4'd6},  // R6
        {2'd1, 16'hCF00, 5'b01000, 4'd6},  // R6
        {2'd1, 16'hC200, 5'b01000, 4'd4}   // R4
    };

    task automatic drive(input logic [1:0] op, input logic [15:0] a);
        @(negedge clk);
        cpu_rd   = op[0];
        cpu_wr   = op[1];
        cpu_addr = a;
        #1;
    endtask

    task automatic check(input string req, input logic [4:0] exp5);
        logic [4:0] act;
        act = {sel_int, sel_slot, stat_valid, stat_data[7], exp_active};
        checks++;
        if (act !== exp5 || stat_data[6:0] !== 7'd0) begin
            errors++;
            $display("FAIL %s actual %b low %h expected %b low 00", req, act, stat_data[6:0], exp5);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(2'd0, 16'h0000);
        check("R1", 5'b00000);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][26:25], VEC[i][24:9]);
            check($sformatf("R%0d", VEC[i][3:0]), VEC[i][8:4]);
        end
        // R1: reset with every flag set
        drive(2'd2, 16'hC007);
        drive(2'd2, 16'hC00B);
        drive(2'd1, 16'hC300);
        drive(2'd0, 16'h0000);
        check("R1", 5'b00001);
        rst_n = 1'b0;
        repeat (2) drive(2'd0, 16'h0000);
        check("R1", 5'b00000);
        rst_n = 1'b1;
        drive(2'd1, 16'hC015);
        check("R1", 5'b00100);
        drive(2'd1, 16'hC017);
        check("R1", 5'b00100);
        drive(2'd1, 16'hC800);
        check("R1", 5'b01000);
        drive(2'd1, 16'hC300);
        check("R1", 5'b10000);
        drive(2'd0, 16'h0000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule